// File: doc/BRIEF.md
# Table Pointer Address Unit

This block keeps a byte pointer into a word-organised program memory and moves it for table read and table write accesses. Software loads the pointer one byte at a time through three byte-wide registers (low, high, upper) and can read all three back. The upper register holds only the bits that the pointer needs.

Each accepted access strobe selects one of four addressing modes. The pointer can stay put, step up or down after the access, or step up before the access so that the access uses the new value. Automatic steps change only the low 21 bits, so the top bit stays fixed and keeps reads inside either the main array or the separate configuration/ID space. For each access the block registers the full 22-bit effective address, the read/write flag and the high/low byte select for a 16-bit memory word. It also presents the block-address and in-block offset fields of the current pointer, which the erase/program and holding-register logic use.

The block is a two-state controller. In `ST_IDLE` a strobe without a register write in the same cycle is accepted, and the controller moves to `ST_ACCESS`. In `ST_ACCESS` the access outputs are valid for one cycle, and the controller always returns to `ST_IDLE`.

Top module: `tptr_addr_unit`

## Requirements
- R1: After reset the pointer is 0, the register readback is 0 and `acc_valid` is low.
- R2: A register write with `reg_wr_sel` 0 loads pointer bits 7:0, with 1 loads bits 15:8, and with 2 loads bits 21:16 from data bits 5:0. Select value 3 changes nothing. The readback bus gives the low byte in bits 7:0, the high byte in 15:8 and the upper byte in 23:16, and bits 23:22 always read 0.
- R3: Mode code 2'b00 (hold) accesses the current pointer and leaves the pointer unchanged.
- R4: Mode code 2'b01 (post-increment) accesses the current pointer, and the pointer then holds that value plus one.
- R5: Mode code 2'b10 (post-decrement) accesses the current pointer, and the pointer then holds that value minus one.
- R6: Mode code 2'b11 (pre-increment) steps the pointer up by one and accesses the stepped value.
- R7: Steps act on bits 20:0 modulo 2^21. Bit 21 never changes through a step.
- R8: A strobe is accepted in `ST_IDLE`. On the following cycle `acc_valid` is high for exactly one cycle, together with `acc_addr` and `acc_is_write`, which equals the strobe's write flag. The updated pointer is visible in that same cycle.
- R9: A strobe that arrives while `acc_valid` is high (state `ST_ACCESS`) is ignored. It produces no access and does not move the pointer.
- R10: A register write in the same cycle as a strobe takes effect, and the strobe is dropped with no access and no step.
- R11: `acc_hi_byte` equals `acc_addr` bit 0 (1 selects the high byte). `blk_addr` equals pointer bits 21:6 and `blk_ofs` equals pointer bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Pointer byte register write strobe |
| reg_wr_sel | input | 2 | Byte select: 0 low, 1 high, 2 upper |
| reg_wr_data | input | 8 | Byte to write |
| reg_rd_bytes | output | 24 | Readback of the three pointer bytes, with unimplemented bits at 0 |
| op_valid | input | 1 | Table access strobe |
| op_is_write | input | 1 | 1 for a table write, 0 for a table read |
| op_mode | input | 2 | Addressing mode code |
| acc_valid | output | 1 | Access outputs are valid this cycle |
| acc_is_write | output | 1 | Write flag of the current access |
| acc_addr | output | 22 | Effective byte address of the current access |
| acc_hi_byte | output | 1 | High/low byte select of the memory word |
| ptr_value | output | 22 | Current (updated) pointer |
| blk_addr | output | 16 | Block address field of the pointer |
| blk_offset | output | 6 | In-block offset field of the pointer |

## Verification
The bench builds the block with its default widths: a 22-bit pointer, 8-bit register bytes and a 6-bit block offset. With these widths a few register writes reach the 21-bit wrap points in both directions and on both sides of the top bit, so the stepped field can be checked at 0x1FFFFF and 0 with bit 21 both clear and set. The bench also exercises a strobe held into the busy state and a strobe that collides with a register write. A scoreboard matches every expected access against the address, write flag and byte select the block produces.

// File: rtl/tptr_pkg.sv
package tptr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD     = 2'b00,
        MODE_POST_INC = 2'b01,
        MODE_POST_DEC = 2'b10,
        MODE_PRE_INC  = 2'b11
    } tptr_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } tptr_state_e;

endpackage

// File: rtl/tptr_step.sv
module tptr_step
    import tptr_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  tptr_mode_e       mode,
    output logic [PTR_W-1:0] access_addr,
    output logic [PTR_W-1:0] next_ptr
);
    localparam int LOW_W = PTR_W - 1;
    localparam logic [LOW_W-1:0] LOW_ONE = {{(LOW_W-1){1'b0}}, 1'b1};

    logic [LOW_W-1:0] low_field;
    logic [LOW_W-1:0] low_up;
    logic [LOW_W-1:0] low_down;
    logic             space_bit;

    assign low_field = cur_ptr[LOW_W-1:0];
    assign space_bit = cur_ptr[PTR_W-1];
    assign low_up    = low_field + LOW_ONE;
    assign low_down  = low_field - LOW_ONE;

    always_comb begin
        unique case (mode)
            MODE_HOLD: begin
                access_addr = cur_ptr;
                next_ptr    = cur_ptr;
            end
            MODE_POST_INC: begin
                access_addr = cur_ptr;
                next_ptr    = {space_bit, low_up};
            end
            MODE_POST_DEC: begin
                access_addr = cur_ptr;
                next_ptr    = {space_bit, low_down};
            end
            MODE_PRE_INC: begin
                access_addr = {space_bit, low_up};
                next_ptr    = {space_bit, low_up};
            end
        endcase
    end
endmodule

// File: rtl/tptr_regs.sv
module tptr_regs #(
    parameter int PTR_W     = 22,
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = (PTR_W + BYTE_W - 1) / BYTE_W,
    parameter int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic                        upd_en,
    input  logic [PTR_W-1:0]            upd_val,
    output logic [PTR_W-1:0]            ptr_q,
    output logic [NUM_BYTES*BYTE_W-1:0] rd_bytes
);
    localparam int PAD_W = NUM_BYTES * BYTE_W;

    logic [PTR_W-1:0] sw_next;
    logic [PAD_W-1:0] cur_pad;

    always_comb begin
        for (int b = 0; b < PTR_W; b++) begin
            if (wr_sel == SEL_W'(b / BYTE_W))
                sw_next[b] = wr_data[b % BYTE_W];
            else
                sw_next[b] = ptr_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wr_en)
            ptr_q <= sw_next;
        else if (upd_en)
            ptr_q <= upd_val;
    end

    always_comb begin
        cur_pad = '0;
        cur_pad[PTR_W-1:0] = ptr_q;
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_rd_byte
        assign rd_bytes[g*BYTE_W +: BYTE_W] = cur_pad[g*BYTE_W +: BYTE_W];
    end

    // R10: software write always wins over an automatic step
    a_r10_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr_q == $past(sw_next));
endmodule

// File: rtl/tptr_ctrl.sv
module tptr_ctrl
    import tptr_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_is_write,
    input  logic             reg_wr_en,
    input  logic [PTR_W-1:0] step_addr,
    output logic             accept,
    output logic             acc_valid,
    output logic             acc_is_write,
    output logic [PTR_W-1:0] acc_addr
);
    tptr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            acc_is_write <= 1'b0;
            acc_addr     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                acc_is_write <= op_is_write;
                acc_addr     <= step_addr;
            end
        end
    end

    always_comb begin
        accept    = 1'b0;
        acc_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid && !reg_wr_en) begin
                    accept  = 1'b1;
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                acc_valid = 1'b1;
                state_d   = ST_IDLE;
            end
        endcase
    end

    // R8: access outputs are a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);
    // R8: an accepted strobe shows up on the next cycle with its write flag
    a_r8_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> acc_valid && acc_is_write == $past(op_is_write));
    // R9: a strobe during the access cycle is never accepted
    a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !accept);
endmodule

// File: rtl/tptr_addr_unit.sv
module tptr_addr_unit
    import tptr_pkg::*;
#(
    parameter int  PTR_W     = 22,
    parameter int  BYTE_W    = 8,
    parameter int  OFS_W     = 6,
    localparam int NUM_BYTES = (PTR_W + BYTE_W - 1) / BYTE_W,
    localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int BLK_W     = PTR_W - OFS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr_en,
    input  logic [SEL_W-1:0]            reg_wr_sel,
    input  logic [BYTE_W-1:0]           reg_wr_data,
    output logic [NUM_BYTES*BYTE_W-1:0] reg_rd_bytes,
    input  logic                        op_valid,
    input  logic                        op_is_write,
    input  logic [1:0]                  op_mode,
    output logic                        acc_valid,
    output logic                        acc_is_write,
    output logic [PTR_W-1:0]            acc_addr,
    output logic                        acc_hi_byte,
    output logic [PTR_W-1:0]            ptr_value,
    output logic [BLK_W-1:0]            blk_addr,
    output logic [OFS_W-1:0]            blk_offset
);
    logic [PTR_W-1:0] step_addr;
    logic [PTR_W-1:0] step_next;
    logic             accept;
    tptr_mode_e       mode;

    assign mode = tptr_mode_e'(op_mode);

    tptr_step #(.PTR_W(PTR_W)) u_step (
        .cur_ptr     (ptr_value),
        .mode        (mode),
        .access_addr (step_addr),
        .next_ptr    (step_next)
    );

    tptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_is_write  (op_is_write),
        .reg_wr_en    (reg_wr_en),
        .step_addr    (step_addr),
        .accept       (accept),
        .acc_valid    (acc_valid),
        .acc_is_write (acc_is_write),
        .acc_addr     (acc_addr)
    );

    tptr_regs #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .upd_en   (accept),
        .upd_val  (step_next),
        .ptr_q    (ptr_value),
        .rd_bytes (reg_rd_bytes)
    );

    assign acc_hi_byte = acc_addr[0];
    assign blk_addr    = ptr_value[PTR_W-1:OFS_W];
    assign blk_offset  = ptr_value[OFS_W-1:0];

    // R7: the space-select bit is untouched unless software writes it
    a_r7_top_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ptr_value[PTR_W-1] == $past(ptr_value[PTR_W-1]));
    // R4: post-increment accesses the old value and steps it up
    a_r4_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && op_valid && !reg_wr_en && op_mode == 2'b01) |=>
        (acc_addr == $past(ptr_value)) &&
        (ptr_value[PTR_W-2:0] == $past(ptr_value[PTR_W-2:0]) + 1'b1));
    // R6: pre-increment accesses the stepped pointer
    a_r6_pre_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && op_valid && !reg_wr_en && op_mode == 2'b11) |=>
        acc_addr == ptr_value);
    // R9: a strobe in the access cycle leaves the pointer alone
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && op_valid && !reg_wr_en) |=> $stable(ptr_value));
    // R10: a colliding register write suppresses the access
    a_r10_collide_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && op_valid && reg_wr_en) |=> !acc_valid);
endmodule

// File: tb/tptr_addr_unit_tb_top.sv
`timescale 1ns/1ps
module tptr_addr_unit_tb_top;

    typedef struct packed {
        logic [21:0] addr;
        logic        wr;
    } exp_acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic [7:0]  reg_wr_data = 8'd0;
    logic [23:0] reg_rd_bytes;
    logic        op_valid = 1'b0;
    logic        op_is_write = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic        acc_valid;
    logic        acc_is_write;
    logic [21:0] acc_addr;
    logic        acc_hi_byte;
    logic [21:0] ptr_value;
    logic [15:0] blk_addr;
    logic [5:0]  blk_offset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_acc_t exp_q[$];
    logic [21:0] m_ptr = '0;

    always #4 clk = ~clk;

    tptr_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_bytes(reg_rd_bytes),
        .op_valid(op_valid), .op_is_write(op_is_write), .op_mode(op_mode),
        .acc_valid(acc_valid), .acc_is_write(acc_is_write), .acc_addr(acc_addr),
        .acc_hi_byte(acc_hi_byte), .ptr_value(ptr_value),
        .blk_addr(blk_addr), .blk_offset(blk_offset)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] m_up(input logic [21:0] p);
        return {p[21], p[20:0] + 21'd1};
    endfunction
    function automatic logic [21:0] m_down(input logic [21:0] p);
        return {p[21], p[20:0] - 21'd1};
    endfunction

    // monitor: pops one expected access per valid cycle
    always @(negedge clk) begin
        if (rst_n && acc_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8", "unexpected access", {10'd0, acc_addr}, 32'hFFFF_FFFF);
            end else begin
                exp_acc_t e;
                e = exp_q.pop_front();
                chk("R8", "acc_addr", {10'd0, acc_addr}, {10'd0, e.addr});
                chk("R8", "acc_is_write", {31'd0, acc_is_write}, {31'd0, e.wr});
                chk("R11", "acc_hi_byte", {31'd0, acc_hi_byte}, {31'd0, e.addr[0]});
            end
        end
    end

    task automatic check_fields(input string req);
        chk(req, "ptr_value", {10'd0, ptr_value}, {10'd0, m_ptr});
        chk("R11", "blk_addr", {16'd0, blk_addr}, {16'd0, m_ptr[21:6]});
        chk("R11", "blk_offset", {26'd0, blk_offset}, {26'd0, m_ptr[5:0]});
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (sel)
            2'd0: m_ptr[7:0]   = data;
            2'd1: m_ptr[15:8]  = data;
            2'd2: m_ptr[21:16] = data[5:0];
            default: ;
        endcase
    endtask

    task automatic load_ptr(input logic [21:0] p);
        wr_reg(2'd0, p[7:0]);
        wr_reg(2'd1, p[15:8]);
        wr_reg(2'd2, {2'b00, p[21:16]});
    endtask

    task automatic do_op(input string req, input logic [1:0] mode, input logic wr);
        exp_acc_t e;
        case (mode)
            2'b00: begin e.addr = m_ptr; end
            2'b01: begin e.addr = m_ptr; m_ptr = m_up(m_ptr); end
            2'b10: begin e.addr = m_ptr; m_ptr = m_down(m_ptr); end
            default: begin m_ptr = m_up(m_ptr); e.addr = m_ptr; end
        endcase
        e.wr = wr;
        exp_q.push_back(e);
        @(negedge clk);
        op_valid = 1'b1; op_mode = mode; op_is_write = wr;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8", "acc_valid", {31'd0, acc_valid}, 32'd1);
        check_fields(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ptr_value", {10'd0, ptr_value}, 32'd0);
        chk("R1", "reg_rd_bytes", {8'd0, reg_rd_bytes}, 32'd0);
        chk("R1", "acc_valid", {31'd0, acc_valid}, 32'd0);

        // R2 byte register loads and readback masking
        wr_reg(2'd0, 8'h34);
        wr_reg(2'd1, 8'h12);
        wr_reg(2'd2, 8'hFF);
        chk("R2", "ptr after loads", {10'd0, ptr_value}, 32'h003F_1234);
        chk("R2", "readback", {8'd0, reg_rd_bytes}, 32'h003F_1234);
        wr_reg(2'd3, 8'hAA);
        chk("R2", "select 3 no effect", {8'd0, reg_rd_bytes}, 32'h003F_1234);

        // R3..R6 modes from a mid-range pointer
        load_ptr(22'h00_1040);
        do_op("R3", 2'b00, 1'b0);
        do_op("R4", 2'b01, 1'b1);
        do_op("R4", 2'b01, 1'b0);
        do_op("R5", 2'b10, 1'b0);
        do_op("R5", 2'b10, 1'b1);
        do_op("R5", 2'b10, 1'b0);
        do_op("R6", 2'b11, 1'b1);
        do_op("R6", 2'b11, 1'b0);
        do_op("R3", 2'b00, 1'b1);

        // R7 wrap points, bit 21 clear and set
        load_ptr(22'h1F_FFFF);
        do_op("R7", 2'b01, 1'b0);
        chk("R7", "wrap to zero", {10'd0, ptr_value}, 32'h0000_0000);
        load_ptr(22'h3F_FFFF);
        do_op("R7", 2'b11, 1'b0);
        chk("R7", "top bit kept on up wrap", {10'd0, ptr_value}, 32'h0020_0000);
        do_op("R7", 2'b10, 1'b1);
        chk("R7", "top bit kept on down wrap", {10'd0, ptr_value}, 32'h003F_FFFF);
        load_ptr(22'h00_0000);
        do_op("R7", 2'b10, 1'b0);
        chk("R7", "down wrap low space", {10'd0, ptr_value}, 32'h001F_FFFF);

        // R9 strobe held into the access cycle: one access, one step
        load_ptr(22'h01_0203);
        exp_q.push_back('{addr: m_ptr, wr: 1'b0});
        m_ptr = m_up(m_ptr);
        @(negedge clk);
        op_valid = 1'b1; op_mode = 2'b01; op_is_write = 1'b0;
        @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9", "acc_valid after busy strobe", {31'd0, acc_valid}, 32'd0);
        check_fields("R9");

        // R10 register write collides with a strobe
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 8'h80;
        op_valid = 1'b1; op_mode = 2'b11;
        @(negedge clk);
        reg_wr_en = 1'b0; op_valid = 1'b0;
        m_ptr[7:0] = 8'h80;
        chk("R10", "acc_valid on collision", {31'd0, acc_valid}, 32'd0);
        check_fields("R10");
        @(negedge clk);
        chk("R10", "no late access", {31'd0, acc_valid}, 32'd0);
        check_fields("R10");

        repeat (2) @(negedge clk);
        chk("R8", "scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule